// File: doc/BRIEF.md
# Host-to-PCI Posted Write Queue with Burst Merging

This block takes 32-bit write requests from the host side and parks each one, with its target address and byte enables, in a small queue. The host does not wait for the bus. A master sequencer empties the queue onto a 32-bit multiplexed address/data bus of the PCI kind. When a queued write lands on the address right after the previous one, it joins the running burst as the next data phase, and no new address phase is issued. Any other address closes the burst. After one idle turnaround cycle a fresh address phase starts.

The host pushes with `wr_valid` and must hold the request while `wr_full` is high. The bus side starts a transaction only when the queue holds at least one entry. The target-ready input can pace data phases when the build parameter enables it. With pacing disabled, every data phase completes in one cycle. All bus outputs come from registers on the rising clock edge, and the target-ready input is sampled on that same edge.

Top module: `pw_post_buf`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bus_frame_n` and `bus_irdy_n` are 1, `bus_ad_oe` is 0 and `wr_full` is 0.
- R2: `wr_full` is 1 exactly when DEPTH entries are held. A request offered while `wr_full` is 1 is dropped and never appears on the bus.
- R3: An address phase is the cycle in which `bus_frame_n` is 0 and `bus_irdy_n` is 1. In it, `bus_ad` carries the burst's first address, `bus_cbe_n` carries 4'b0111 (memory write) and `bus_ad_oe` is 1.
- R4: In a data phase (`bus_irdy_n` 0), `bus_ad` carries the entry's data, `bus_cbe_n` carries the bitwise inverse of its byte enables, and `bus_ad_oe` is 1.
- R5: An entry whose address equals the previous entry's address plus 4 continues the same burst with no new address phase. While `bus_trdy_n` stays 0, its data phase follows in the very next cycle.
- R6: An entry whose address is not the previous address plus 4 ends the burst. The cycle after the last data phase completes is idle (`bus_frame_n` 1, `bus_irdy_n` 1, `bus_ad_oe` 0), and a new address phase follows.
- R7: `bus_frame_n` is 1 during the last data phase of a burst, which is when the queue holds no next entry or the next entry is not sequential.
- R8: With WAIT_TRDY=1, a data phase during which `bus_trdy_n` is sampled 1 repeats unchanged in the next cycle.
- R9: Entries leave on the bus in the order they were pushed.
- R10: With the queue empty and the bus idle, no transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write request present |
| wr_addr | input | 32 | Host write byte address |
| wr_data | input | 32 | Host write data |
| wr_be | input | 4 | Host byte enables, active high |
| wr_full | output | 1 | Queue full; host must hold its request |
| bus_ad | output | 32 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for `bus_ad` |
| bus_cbe_n | output | 4 | Command in address phase, inverted byte enables in data phase |
| bus_frame_n | output | 1 | Transaction framing, active low |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |

## Verification
The bench builds the block with DEPTH=4 and WAIT_TRDY=1. Holding target ready high lets a whole group of writes pile up behind a stalled first data phase. Burst boundaries then depend only on the addresses, and the bench can predict them from the vector table. The depth of four lets a short stalled load fill the queue, so the full flag and the dropping of a fifth write can both be checked. Pacing also makes the hold of a stalled data phase visible on the bus.

// File: rtl/pw_pkg.sv
package pw_pkg;
  parameter int unsigned AD_W = 32;
  parameter int unsigned BE_W = AD_W / 8;
  localparam logic [BE_W-1:0] CMD_MEM_WR = 4'b0111;

  typedef struct packed {
    logic [AD_W-1:0] addr;
    logic [AD_W-1:0] data;
    logic [BE_W-1:0] be;
  } pw_entry_t;
endpackage

// File: rtl/pw_queue.sv
module pw_queue
  import pw_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  pw_entry_t         push_ent,
  input  logic              pop,
  output pw_entry_t         peek0,
  output pw_entry_t         peek1,
  output logic [AD_W-1:0]   peek2_addr,
  output logic [CNT_W-1:0]  count
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  pw_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] rd1;
  logic [PTR_W-1:0] rd2;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd1        = rd_ptr + PTR_W'(1);
  assign rd2        = rd_ptr + PTR_W'(2);
  assign peek0      = mem[rd_ptr];
  assign peek1      = mem[rd1];
  assign peek2_addr = mem[rd2].addr;
endmodule

// File: rtl/pw_bus_seq.sv
module pw_bus_seq
  import pw_pkg::*;
#(
  parameter int unsigned CNT_W     = 3,
  parameter bit          WAIT_TRDY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  pw_entry_t        e0,
  input  pw_entry_t        e1,
  input  logic [AD_W-1:0]  e2_addr,
  input  logic             trdy_n,
  output logic             pop,
  output logic [AD_W-1:0]  ad,
  output logic             ad_oe,
  output logic [BE_W-1:0]  cbe_n,
  output logic             frame_n,
  output logic             irdy_n
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} seq_state_t;
  seq_state_t state;
  logic       accept;

  function automatic logic ends_burst(input logic have_next,
                                      input logic [AD_W-1:0] cur,
                                      input logic [AD_W-1:0] nxt);
    return !(have_next && (nxt == cur + AD_W'(4)));
  endfunction

  assign accept = !WAIT_TRDY || !trdy_n;
  assign pop    = (state == S_DATA) && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ad      <= '0;
      ad_oe   <= 1'b0;
      cbe_n   <= '1;
      frame_n <= 1'b1;
      irdy_n  <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (count != '0) begin
            state   <= S_ADDR;
            ad      <= e0.addr;
            cbe_n   <= CMD_MEM_WR;
            frame_n <= 1'b0;
            irdy_n  <= 1'b1;
            ad_oe   <= 1'b1;
          end
        end
        S_ADDR: begin
          state   <= S_DATA;
          ad      <= e0.data;
          cbe_n   <= ~e0.be;
          irdy_n  <= 1'b0;
          frame_n <= ends_burst(count >= CNT_W'(2), e0.addr, e1.addr);
        end
        S_DATA: begin
          if (accept) begin
            if (frame_n) begin
              state  <= S_IDLE;
              irdy_n <= 1'b1;
              ad_oe  <= 1'b0;
              cbe_n  <= '1;
            end else begin
              ad      <= e1.data;
              cbe_n   <= ~e1.be;
              frame_n <= ends_burst(count >= CNT_W'(3), e1.addr, e2_addr);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_post_buf.sv
module pw_post_buf
  import pw_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter bit          WAIT_TRDY = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_valid,
  input  logic [31:0]     wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      wr_be,
  output logic            wr_full,
  output logic [31:0]     bus_ad,
  output logic            bus_ad_oe,
  output logic [3:0]      bus_cbe_n,
  output logic            bus_frame_n,
  output logic            bus_irdy_n,
  input  logic            bus_trdy_n
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             q_push;
  logic             q_pop;
  logic [CNT_W-1:0] q_count;
  pw_entry_t        q_in;
  pw_entry_t        q_e0;
  pw_entry_t        q_e1;
  logic [AD_W-1:0]  q_e2_addr;

  assign wr_full = (q_count == CNT_W'(DEPTH));
  assign q_push  = wr_valid && !wr_full;
  assign q_in    = '{addr: wr_addr, data: wr_data, be: wr_be};

  pw_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (q_push),
    .push_ent   (q_in),
    .pop        (q_pop),
    .peek0      (q_e0),
    .peek1      (q_e1),
    .peek2_addr (q_e2_addr),
    .count      (q_count)
  );

  pw_bus_seq #(.CNT_W(CNT_W), .WAIT_TRDY(WAIT_TRDY)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .count   (q_count),
    .e0      (q_e0),
    .e1      (q_e1),
    .e2_addr (q_e2_addr),
    .trdy_n  (bus_trdy_n),
    .pop     (q_pop),
    .ad      (bus_ad),
    .ad_oe   (bus_ad_oe),
    .cbe_n   (bus_cbe_n),
    .frame_n (bus_frame_n),
    .irdy_n  (bus_irdy_n)
  );
endmodule

// File: rtl/pw_post_buf_chk.sv
module pw_post_buf_chk #(
  parameter int unsigned DEPTH     = 4,
  parameter bit          WAIT_TRDY = 1'b1,
  parameter int unsigned CNT_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_full,
  input logic             q_pop,
  input logic [CNT_W-1:0] q_count,
  input logic [31:0]      bus_ad,
  input logic             bus_ad_oe,
  input logic [3:0]       bus_cbe_n,
  input logic             bus_frame_n,
  input logic             bus_irdy_n,
  input logic             bus_trdy_n
);
  logic done_now;
  assign done_now = !WAIT_TRDY || !bus_trdy_n;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_full && !q_pop) |=> (q_count == $past(q_count)));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  // R3
  addr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_frame_n) |-> (bus_irdy_n && bus_ad_oe && bus_cbe_n == 4'b0111));

  // R4
  data_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_irdy_n |-> bus_ad_oe);

  // R5
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_irdy_n && !bus_frame_n && done_now) |=> !bus_irdy_n);

  // R6
  turn_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_irdy_n && bus_frame_n && done_now) |=> (bus_frame_n && bus_irdy_n && !bus_ad_oe));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (WAIT_TRDY && !bus_irdy_n && bus_trdy_n) |=>
      (!bus_irdy_n && $stable(bus_ad) && $stable(bus_cbe_n) && $stable(bus_frame_n)));

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (q_count == '0 && bus_frame_n && bus_irdy_n) |=> bus_frame_n);
endmodule

bind pw_post_buf pw_post_buf_chk #(.DEPTH(DEPTH), .WAIT_TRDY(WAIT_TRDY), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_full     (wr_full),
  .q_pop       (q_pop),
  .q_count     (q_count),
  .bus_ad      (bus_ad),
  .bus_ad_oe   (bus_ad_oe),
  .bus_cbe_n   (bus_cbe_n),
  .bus_frame_n (bus_frame_n),
  .bus_irdy_n  (bus_irdy_n),
  .bus_trdy_n  (bus_trdy_n)
);

// File: tb/pw_post_buf_bench.sv
`timescale 1ns/1ps
module pw_post_buf_bench;
  localparam int NV = 14;
  // {group_end, addr, data, be}
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 32'h0000_1000, 32'hA000_0001, 4'hF},
    {1'b0, 32'h0000_1004, 32'hA000_0002, 4'h3},
    {1'b0, 32'h0000_1008, 32'hA000_0003, 4'hC},
    {1'b1, 32'h0000_100C, 32'hA000_0004, 4'h1},
    {1'b0, 32'h0000_2000, 32'hB000_0001, 4'hF},
    {1'b1, 32'h0000_3000, 32'hB000_0002, 4'h8},
    {1'b0, 32'h0000_4000, 32'hC000_0001, 4'hF},
    {1'b0, 32'h0000_4004, 32'hC000_0002, 4'h6},
    {1'b0, 32'h0000_5000, 32'hC000_0003, 4'hF},
    {1'b1, 32'h0000_5004, 32'hC000_0004, 4'h9},
    {1'b1, 32'h0000_6010, 32'hD000_0001, 4'h2},
    {1'b0, 32'h0000_7000, 32'hE000_0001, 4'hF},
    {1'b0, 32'h0000_7004, 32'hE000_0002, 4'hA},
    {1'b1, 32'h0000_7008, 32'hE000_0003, 4'h5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic wr_full;
  logic [31:0] bus_ad;
  logic bus_ad_oe;
  logic [3:0] bus_cbe_n;
  logic bus_frame_n;
  logic bus_irdy_n;
  logic bus_trdy_n = 1'b1;

  always #2 clk = ~clk;

  pw_post_buf #(.DEPTH(4), .WAIT_TRDY(1'b1)) u_pw_post_buf (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_full(wr_full), .bus_ad(bus_ad),
    .bus_ad_oe(bus_ad_oe), .bus_cbe_n(bus_cbe_n), .bus_frame_n(bus_frame_n),
    .bus_irdy_n(bus_irdy_n), .bus_trdy_n(bus_trdy_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bus monitor: records every completed data phase
  logic [31:0] rec_addr [64];
  logic [31:0] rec_data [64];
  logic [3:0]  rec_be   [64];
  logic        rec_new  [64];
  logic        rec_last [64];
  int          rec_n = 0;
  logic [31:0] cur_addr = '0;
  logic        addr_seen = 1'b0;
  logic        prev_cont = 1'b0;
  logic        prev_end  = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_end)
        chk(bus_frame_n && bus_irdy_n && !bus_ad_oe, "R6", "idle after last phase",
            {29'd0, bus_frame_n, bus_irdy_n, bus_ad_oe}, 32'h6);
      if (prev_cont && !bus_trdy_n)
        chk(!bus_irdy_n, "R5", "no wait between data phases", {31'd0, bus_irdy_n}, 32'h0);
      if (!bus_frame_n && bus_irdy_n) begin
        chk(bus_cbe_n == 4'b0111 && bus_ad_oe, "R3", "address phase command",
            {27'd0, bus_ad_oe, bus_cbe_n}, 32'h17);
        cur_addr  <= bus_ad;
        addr_seen <= 1'b1;
      end
      prev_cont <= !bus_irdy_n && !bus_trdy_n && !bus_frame_n;
      prev_end  <= !bus_irdy_n && !bus_trdy_n && bus_frame_n;
      if (!bus_irdy_n && !bus_trdy_n && rec_n < 64) begin
        rec_addr[rec_n] <= cur_addr;
        rec_data[rec_n] <= bus_ad;
        rec_be[rec_n]   <= ~bus_cbe_n;
        rec_new[rec_n]  <= addr_seen;
        rec_last[rec_n] <= bus_frame_n;
        addr_seen       <= 1'b0;
        rec_n           <= rec_n + 1;
      end
    end
  end

  task automatic push_one(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_recs(input int target);
    for (int k = 0; k < 60 && rec_n < target; k++) begin
      @(posedge clk); #1;
    end
    repeat (4) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] burst_a;
    int gstart;
    int base;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R1 during reset
    chk(bus_frame_n && bus_irdy_n && !bus_ad_oe && !wr_full, "R1", "outputs in reset",
        {28'd0, bus_frame_n, bus_irdy_n, bus_ad_oe, wr_full}, 32'hC);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(bus_frame_n && bus_irdy_n && !bus_ad_oe && !wr_full, "R1", "outputs after reset",
        {28'd0, bus_frame_n, bus_irdy_n, bus_ad_oe, wr_full}, 32'hC);
    // R10: empty queue stays quiet
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_frame_n && bus_irdy_n, "R10", "no start while empty",
          {30'd0, bus_frame_n, bus_irdy_n}, 32'h3);
    end
    @(posedge clk); #1;

    // vector table, group by group, with target ready held during each load
    gstart = 0;
    for (int i = 0; i < NV; i++) begin
      if (i == gstart) bus_trdy_n = 1'b1;
      push_one(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]);
      if (VEC[i][68]) begin
        bus_trdy_n = 1'b0;
        wait_recs(i + 1);
        gstart = i + 1;
      end
    end

    chk(rec_n == NV, "R9", "data phase count", rec_n, NV);
    burst_a = '0;
    for (int i = 0; i < NV; i++) begin
      logic first, last;
      first = (i == 0) || VEC[i-1][68] || (VEC[i][67:36] != VEC[i-1][67:36] + 32'd4);
      last  = VEC[i][68] || (VEC[i+1 < NV ? i+1 : i][67:36] != VEC[i][67:36] + 32'd4);
      if (first) burst_a = VEC[i][67:36];
      chk(rec_data[i] == VEC[i][35:4], "R9", "data order", rec_data[i], VEC[i][35:4]);
      chk(rec_be[i] == VEC[i][3:0], "R4", "byte enables", {28'd0, rec_be[i]}, {28'd0, VEC[i][3:0]});
      chk(rec_new[i] == first, "R5", "address phase before entry", {31'd0, rec_new[i]}, {31'd0, first});
      chk(rec_addr[i] == burst_a, "R3", "burst start address", rec_addr[i], burst_a);
      chk(rec_last[i] == last, "R7", "frame on last phase", {31'd0, rec_last[i]}, {31'd0, last});
    end

    // full queue, dropped extra write, stalled data phase hold
    base = rec_n;
    bus_trdy_n = 1'b1;
    for (int i = 0; i < 4; i++)
      push_one(32'h0000_8000 + 32'(i * 4), 32'hF000_0000 + 32'(i), 4'hF);
    @(negedge clk);
    chk(wr_full, "R2", "full after four entries", {31'd0, wr_full}, 32'h1);
    chk(!bus_irdy_n && bus_ad == 32'hF000_0000, "R8", "stalled data phase",
        bus_ad, 32'hF000_0000);
    @(posedge clk); #1;
    push_one(32'h0000_8010, 32'hDEAD_BEEF, 4'hF);
    @(negedge clk);
    chk(!bus_irdy_n && bus_ad == 32'hF000_0000, "R8", "data phase held", bus_ad, 32'hF000_0000);
    chk(wr_full, "R2", "still full after dropped push", {31'd0, wr_full}, 32'h1);
    @(posedge clk); #1;
    bus_trdy_n = 1'b0;
    wait_recs(base + 5);
    chk(rec_n == base + 4, "R2", "dropped write absent", rec_n - base, 4);
    chk(rec_data[base + 3] == 32'hF000_0003 && rec_last[base + 3], "R7", "last of full burst",
        rec_data[base + 3], 32'hF000_0003);
    chk(!wr_full, "R2", "not full after drain", {31'd0, wr_full}, 32'h0);
    summary();
  end
endmodule